// File: doc/BRIEF.md
# Sigma-Delta Decimation Filter

This block turns the one-bit stream of an oversampling sigma-delta modulator into signed 18-bit samples. Every accepted input bit is taken as +1 or −1 and fed to a five-stage cascaded integrator-comb decimator. The decimator gives one result for every 64 accepted bits. That result is scaled down to the output width and checked for overrange. It then passes through a first-order DC-blocking filter, unless a bypass pin selects the unfiltered value.

An input that drives the decimator past full scale pins the output word at the matching extreme code. The output stays there for every frame in which the condition lasts, whether or not the DC filter is bypassed. Input bits come with a valid strobe, so the modulator can run slower than the block clock. Cycles without the strobe do not disturb the result.

Top module: `sd_decimator`

## Requirements
- R1: A synchronous reset clears the integrators, the comb delays, the DC filter state and the outputs. On the clock after reset is seen, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high for exactly one clock per 64 accepted bits. It rises on the second rising edge after the edge that accepts the 64th bit of a frame.
- R3: An input bit of 1 counts as +1 and a bit of 0 counts as −1. The decimated value is the sum of the input history weighted by the coefficients of the fifth power of a 64-tap unit boxcar. The newest bit has tap 0, and history before reset counts as zero. This value is divided by 2^13 and rounded toward minus infinity to give the scaled value.
- R4: If the scaled value is above 131071, the output is 131071 (0x1FFFF). If it is below −131071, the output is −131072 (0x20000). This holds for every such frame, whatever the bypass pin is.
- R5: With `hpf_bypass` high and the scaled value in range, the output equals the scaled value.
- R6: With `hpf_bypass` low and the scaled value in range, the output is the DC filter result. The filter computes y = ((x − x_prev)·2^S) + y − (y >>> S), where S = HPF_SHIFT and x is the scaled value clamped to the 18-bit range. The output is y >>> S, saturated to 18 bits. The filter state is updated on every frame, whatever the bypass pin is.
- R7: A constant in-range input density with the filter active gives an output that decays to within ±2 of zero.
- R8: Cycles with `in_valid` low are ignored. The bit presented in such cycles has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a modulator bit to be accepted |
| in_bit | input | 1 | Modulator bit, 1 = +1, 0 = −1 |
| hpf_bypass | input | 1 | High to skip the DC filter |
| out_valid | output | 1 | One-clock pulse per output sample |
| out_data | output | 18 | Two's-complement output sample |

## Verification
The frame-timing properties assume that `in_valid` is never X outside reset, and that reset lasts at least one clock before the first accepted bit. The bench drives every input on the falling edge, so each property sees clean values at the rising edge. The bypass property takes the bypass level from the edge that registers the output. The bench may therefore change the bypass pin in any cycle, including the cycle that completes a frame. Long runs of ones and zeros push the scaled value to both overrange regions. Random gaps in the valid strobe, with random bits presented in those gaps, show that idle cycles carry no weight.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;

    // Range classification of one decimated sample before the DC filter.
    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_HIGH = 2'd1,
        RNG_LOW  = 2'd2
    } range_e;

endpackage

// File: rtl/sd_cic_integ.sv
module sd_cic_integ #(
    parameter int ORDER      = 5,
    parameter int RATIO_LOG2 = 6,
    parameter int ACC_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic [ACC_W-1:0] frame_sum,
    output logic             frame_stb
);

    typedef struct packed {
        logic [RATIO_LOG2-1:0]        phase;
        logic [ORDER-1:0][ACC_W-1:0]  acc;
        logic [ACC_W-1:0]             sum;
        logic                         stb;
    } integ_st_t;

    integ_st_t st_d, st_q;

    always_comb begin
        logic [ACC_W-1:0] carry;
        st_d     = st_q;
        st_d.stb = 1'b0;
        carry    = '0;
        if (in_valid) begin
            // +1 for a one, -1 (all ones) for a zero; sums wrap modulo 2^ACC_W
            carry = in_bit ? ACC_W'(1) : '1;
            for (int i = 0; i < ORDER; i++) begin
                st_d.acc[i] = st_q.acc[i] + carry;
                carry       = st_d.acc[i];
            end
            st_d.phase = st_q.phase + 1'b1;
            if (st_q.phase == '1) begin
                st_d.sum = carry;
                st_d.stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_sum = st_q.sum;
    assign frame_stb = st_q.stb;

endmodule

// File: rtl/sd_cic_comb.sv
module sd_cic_comb
    import sd_decim_pkg::*;
#(
    parameter int ORDER    = 5,
    parameter int ACC_W    = 32,
    parameter int OUT_W    = 18,
    parameter int SCALE_SH = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        frame_sum,
    input  logic                    frame_stb,
    output logic signed [OUT_W-1:0] x_val,
    output range_e                  x_rng,
    output logic                    x_stb
);

    localparam int POS_LIM_I = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(POS_LIM_I);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;
    localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
    } comb_st_t;

    comb_st_t st_d, st_q;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        logic [ACC_W-1:0] stage;
        st_d  = st_q;
        stage = frame_sum;
        for (int i = 0; i < ORDER; i++) begin
            if (frame_stb) begin
                st_d.dly[i] = stage;
            end
            stage = stage - st_q.dly[i];
        end
        scaled = $signed(stage) >>> SCALE_SH;
    end

    always_comb begin
        if (scaled > POS_LIM) begin
            x_rng = RNG_HIGH;
            x_val = OUT_MAX;
        end else if (scaled < NEG_LIM) begin
            x_rng = RNG_LOW;
            x_val = OUT_MIN;
        end else begin
            x_rng = RNG_IN;
            x_val = scaled[OUT_W-1:0];
        end
    end

    assign x_stb = frame_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sd_dc_block.sv
module sd_dc_block
    import sd_decim_pkg::*;
#(
    parameter int OUT_W     = 18,
    parameter int HPF_SHIFT = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OUT_W-1:0] x_val,
    input  range_e                  x_rng,
    input  logic                    x_stb,
    input  logic                    hpf_bypass,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);

    localparam int Y_W = OUT_W + 4 + HPF_SHIFT;
    localparam logic signed [Y_W-1:0]   Y_MAX   = Y_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [Y_W-1:0]   Y_MIN   = -Y_MAX - 1;
    localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic signed [OUT_W-1:0] x_prev;
        logic signed [Y_W-1:0]   y;
        logic [OUT_W-1:0]        data;
        logic                    vld;
    } dc_st_t;

    dc_st_t st_d, st_q;

    always_comb begin
        logic signed [Y_W-1:0]   dx;
        logic signed [Y_W-1:0]   y_new;
        logic signed [Y_W-1:0]   y_int;
        logic signed [OUT_W-1:0] y_sat;
        st_d     = st_q;
        st_d.vld = x_stb;
        dx       = Y_W'(x_val) - Y_W'(st_q.x_prev);
        y_new    = (dx <<< HPF_SHIFT) + st_q.y - (st_q.y >>> HPF_SHIFT);
        y_int    = y_new >>> HPF_SHIFT;
        if (y_int > Y_MAX) begin
            y_sat = OUT_MAX;
        end else if (y_int < Y_MIN) begin
            y_sat = OUT_MIN;
        end else begin
            y_sat = y_int[OUT_W-1:0];
        end
        if (x_stb) begin
            st_d.x_prev = x_val;
            st_d.y      = y_new;
            unique case (x_rng)
                RNG_HIGH: st_d.data = OUT_MAX;
                RNG_LOW:  st_d.data = OUT_MIN;
                default:  st_d.data = hpf_bypass ? x_val : y_sat;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/sd_decimator.sv
module sd_decimator
    import sd_decim_pkg::*;
#(
    parameter int ORDER      = 5,
    parameter int RATIO_LOG2 = 6,
    parameter int OUT_W      = 18,
    parameter int HPF_SHIFT  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             hpf_bypass,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    // Gain of the decimator is 2^(ORDER*RATIO_LOG2); two guard bits keep
    // the signed full-scale value representable.
    localparam int ACC_W    = ORDER * RATIO_LOG2 + 2;
    localparam int SCALE_SH = ORDER * RATIO_LOG2 - (OUT_W - 1);

    logic [ACC_W-1:0]        frame_sum;
    logic                    frame_stb;
    logic signed [OUT_W-1:0] x_val;
    range_e                  x_rng;
    logic                    x_stb;

    sd_cic_integ #(
        .ORDER      (ORDER),
        .RATIO_LOG2 (RATIO_LOG2),
        .ACC_W      (ACC_W)
    ) integ_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .frame_sum (frame_sum),
        .frame_stb (frame_stb)
    );

    sd_cic_comb #(
        .ORDER    (ORDER),
        .ACC_W    (ACC_W),
        .OUT_W    (OUT_W),
        .SCALE_SH (SCALE_SH)
    ) comb_i (
        .clk       (clk),
        .rst       (rst),
        .frame_sum (frame_sum),
        .frame_stb (frame_stb),
        .x_val     (x_val),
        .x_rng     (x_rng),
        .x_stb     (x_stb)
    );

    sd_dc_block #(
        .OUT_W     (OUT_W),
        .HPF_SHIFT (HPF_SHIFT)
    ) dc_i (
        .clk        (clk),
        .rst        (rst),
        .x_val      (x_val),
        .x_rng      (x_rng),
        .x_stb      (x_stb),
        .hpf_bypass (hpf_bypass),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

endmodule

// File: rtl/sd_decimator_chk.sv
module sd_decimator_chk
    import sd_decim_pkg::*;
#(
    parameter int RATIO_LOG2 = 6,
    parameter int OUT_W      = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    hpf_bypass,
    input logic                    out_valid,
    input logic [OUT_W-1:0]        out_data,
    input logic signed [OUT_W-1:0] x_val,
    input range_e                  x_rng,
    input logic                    x_stb
);

    localparam logic [OUT_W-1:0] CODE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] CODE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [RATIO_LOG2-1:0] bit_cnt;
    logic                  rst_seen;
    logic                  wrap;

    assign wrap = !rst && in_valid && (bit_cnt == '1);

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            bit_cnt <= '0;
        end else if (in_valid) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R1: outputs cleared on the clock after reset
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r1: assert (!out_valid && out_data == '0);
        end
    end

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_frame_to_valid_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ##1 out_valid);

    p_valid_from_frame_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(wrap, 2));

    p_sat_high_r4: assert property (@(posedge clk) disable iff (rst)
        (x_stb && x_rng == RNG_HIGH) |=> (out_valid && out_data == CODE_MAX));

    p_sat_low_r4: assert property (@(posedge clk) disable iff (rst)
        (x_stb && x_rng == RNG_LOW) |=> (out_valid && out_data == CODE_MIN));

    p_bypass_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (x_stb && x_rng == RNG_IN && hpf_bypass) |=> (out_data == $past(x_val)));

endmodule

bind sd_decimator sd_decimator_chk #(
    .RATIO_LOG2 (RATIO_LOG2),
    .OUT_W      (OUT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .hpf_bypass (hpf_bypass),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .x_val      (x_val),
    .x_rng      (x_rng),
    .x_stb      (x_stb)
);

// File: tb/sd_decimator_tb_top.sv
module sd_decimator_tb_top;

    localparam int TB_SHIFT = 6;
    localparam int NTAPS    = 316;
    localparam int SCALE    = 13;
    localparam longint PMAX = 131071;
    localparam longint NMIN = -131072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        hpf_bypass = 1'b1;
    logic        out_valid;
    logic [17:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sd_decimator #(.HPF_SHIFT(TB_SHIFT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .hpf_bypass (hpf_bypass),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // ---------------- behavioural reference model ----------------
    longint h[NTAPS];
    int     hist[$];
    int     m_cnt;
    bit     m_pend;
    longint m_cic;
    longint m_x1, m_y;
    bit     m_vld;
    longint m_data;
    string  m_tag;

    function automatic longint sat18(longint v);
        if (v > PMAX) return PMAX;
        if (v < NMIN) return NMIN;
        return v;
    endfunction

    initial begin
        longint tmp[NTAPS];
        int len;
        foreach (h[k]) h[k] = 0;
        h[0] = 1;
        len = 1;
        for (int s = 0; s < 5; s++) begin
            foreach (tmp[k]) tmp[k] = 0;
            for (int k = 0; k < len + 63; k++)
                for (int j = 0; j < 64; j++)
                    if (k - j >= 0 && k - j < len) tmp[k] += h[k - j];
            len = len + 63;
            foreach (h[k]) h[k] = tmp[k];
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_cnt = 0; m_pend = 0; m_cic = 0;
            m_x1 = 0; m_y = 0; m_vld = 0; m_data = 0; m_tag = "R1";
        end else begin
            m_vld = 0;
            if (m_pend) begin
                longint v, x;
                bit hi, lo;
                v  = m_cic >>> SCALE;
                hi = (v > PMAX);
                lo = (v < -PMAX);
                x  = sat18(v);
                m_y  = ((x - m_x1) <<< TB_SHIFT) + m_y - (m_y >>> TB_SHIFT);
                m_x1 = x;
                if (hi) begin m_data = PMAX; m_tag = "R4"; end
                else if (lo) begin m_data = NMIN; m_tag = "R4"; end
                else if (hpf_bypass) begin m_data = x; m_tag = "R3 R5"; end
                else begin m_data = sat18(m_y >>> TB_SHIFT); m_tag = "R6"; end
                m_vld  = 1;
                m_pend = 0;
            end
            if (in_valid) begin
                hist.push_front(in_bit ? 1 : -1);
                if (hist.size() > NTAPS) void'(hist.pop_back());
                m_cnt++;
                if (m_cnt == 64) begin
                    m_cnt = 0;
                    m_cic = 0;
                    foreach (hist[k]) m_cic += h[k] * hist[k];
                    m_pend = 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (out_valid !== m_vld) begin
                n_fail++;
                $display("FAIL R2 R8 out_valid actual=%0b expected=%0b t=%0t", out_valid, m_vld, $time);
            end
            if (m_vld) begin
                n_checks++;
                if (longint'($signed(out_data)) != m_data) begin
                    n_fail++;
                    $display("FAIL %s out_data actual=%0d expected=%0d t=%0t",
                             m_tag, $signed(out_data), m_data, $time);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    int tri_v = 0, tri_dir = 1, err_acc = 0;

    // mode 0 alternating, 1 ones, 2 zeros, 3 density 3/4, 4 tracking modulator
    task automatic drive(int nbits, int mode, int gap_pct, bit toggle_byp);
        int k = 0;
        while (k < nbits) begin
            @(negedge clk);
            if (toggle_byp && ($urandom_range(0, 999) == 0)) hpf_bypass = ~hpf_bypass;
            if ($urandom_range(0, 99) < gap_pct) begin
                in_valid = 1'b0;
                in_bit   = 1'($urandom_range(0, 1));
            end else begin
                in_valid = 1'b1;
                case (mode)
                    0: in_bit = k[0];
                    1: in_bit = 1'b1;
                    2: in_bit = 1'b0;
                    3: in_bit = (k % 4) != 0;
                    default: begin
                        tri_v += tri_dir;
                        if (tri_v >= 900 || tri_v <= -900) tri_dir = -tri_dir;
                        err_acc += tri_v;
                        in_bit = (err_acc >= 0);
                        err_acc -= in_bit ? 1000 : -1000;
                    end
                endcase
                k++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_reset_state();
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state actual=%0b/%0d expected=0/0", out_valid, out_data);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check_reset_state();                       // R1
        rst = 1'b0;

        hpf_bypass = 1'b1;
        drive(64 * 20, 0, 30, 1'b0);               // R3 R5 R8 alternating with gaps
        hpf_bypass = 1'b0;
        drive(64 * 20, 1, 10, 1'b0);               // R4 positive overrange, filter on
        hpf_bypass = 1'b1;
        drive(64 * 20, 2, 10, 1'b0);               // R4 negative overrange, bypassed
        drive(64 * 300, 4, 25, 1'b1);              // R3 R5 R6 moving signal, bypass toggling
        hpf_bypass = 1'b0;
        drive(64 * 1000, 3, 0, 1'b0);              // R7 constant density, filter on
        repeat (4) @(negedge clk);
        n_checks++;
        if ($signed(out_data) > 2 || $signed(out_data) < -2) begin
            n_fail++;
            $display("FAIL R7 decayed output actual=%0d expected=within +-2 of 0", $signed(out_data));
        end

        // Reset in mid-frame, then a fresh frame from zero history (R1, R2)
        drive(37, 4, 0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();                       // R1
        rst = 1'b0;
        hpf_bypass = 1'b1;
        drive(64 * 10, 4, 20, 1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule